// File: doc/BRIEF.md
# Transfer Region Ownership Tracker

This block sits on the sending side of a link that moves messages to a peer either through a small mailbox or through a shared, contiguous transfer buffer. Each message is routed on its own. A message whose length exceeds three 128-byte mailbox fragments (more than 384 bytes) goes over the shared buffer, but only once capability negotiation has completed. Every other message goes through the mailbox.

For a buffer message the block reserves a contiguous region. While the peer has not acknowledged the transfer, that region belongs to the peer. Regions are handed out in ring order. Several transfers may be outstanding at once. Acknowledgements release regions strictly oldest first. When no suitable region is free, the block answers the request with a stall, and the requester retries later. Moving the data is not part of this block.

Negotiation is a three-state machine:
- NEG_OFF goes to NEG_WAIT when an allocation notice is sent (transition T_NOTICE).
- NEG_WAIT goes to NEG_ON when the allocation acknowledgement arrives (transition T_ACCEPT).
- NEG_ON holds until reset.

Each request takes one of four allocation outcomes:
- PICK_MBOX: mailbox path.
- PICK_HEAD: region at the ring head.
- PICK_ZERO: region restarted or wrapped to offset 0.
- PICK_STALL: no region is granted.

Top module: `xfer_region_tracker`

## Requirements
- R1: A cycle with `req_valid_i` high yields, on the following cycle, exactly one of `grant_valid_o` or `stall_o`. Neither output is high in a cycle that does not follow a request.
- R2: After reset, all outputs are 0, negotiation is in NEG_OFF, and no region is outstanding.
- R3: `dma_enabled_o` rises only after an allocation notice has been seen and a later allocation acknowledgement has been seen. An acknowledgement seen in NEG_OFF, or in the same cycle as the notice, is ignored.
- R4: A request of at most 384 bytes, or any request while `dma_enabled_o` is 0, is granted on the mailbox path: `grant_dma_o`=0, `grant_off_o`=0 and `grant_len_o`=`req_len_i`. It never stalls.
- R5: The path is chosen for each message alone. A short message that follows a buffer message still uses the mailbox.
- R6: With regions outstanding and the ring head above the oldest region, a buffer message that fits between the head and the buffer end is placed at the head. The head then advances by its length.
- R7: With nothing outstanding, a buffer message of at most BUF_BYTES is placed at offset 0.
- R8: If the space from the head to the end is too small, the message wraps to offset 0 when it fits below the oldest outstanding region. Otherwise the request stalls.
- R9: After a wrap, only the gap from the head up to the oldest outstanding region is usable. An exact fit is granted. A gap of zero stalls.
- R10: Each `xfer_ack_i` returns the oldest outstanding region to the sender.
- R11: When MAX_OUT regions are outstanding, a buffer message stalls even if the space would fit.
- R12: `xfer_ack_i` with nothing outstanding sets `ack_err_o`, which stays set until reset. The ownership state is left unchanged.
- R13: A buffer message longer than BUF_BYTES always stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_notice_i | input | 1 | Pulse: allocation notice sent to peer |
| alloc_ack_i | input | 1 | Pulse: allocation acknowledgement received |
| req_valid_i | input | 1 | Message send request |
| req_len_i | input | LEN_W | Message length in bytes |
| xfer_ack_i | input | 1 | Pulse: peer acknowledged oldest transfer |
| grant_valid_o | output | 1 | Request granted |
| grant_dma_o | output | 1 | 1 = buffer path, 0 = mailbox path |
| grant_off_o | output | OFF_W | Region byte offset (0 for mailbox) |
| grant_len_o | output | LEN_W | Granted length in bytes |
| stall_o | output | 1 | Request refused, retry later |
| dma_enabled_o | output | 1 | Negotiation complete |
| ack_err_o | output | 1 | Sticky spurious-acknowledge flag |

## Verification
The grant or stall for a request is registered, so it appears one cycle after the edge that samples `req_valid_i`. The effect of an acknowledgement, whether a freed region or `ack_err_o`, is visible on the next request or one cycle after the edge that samples it. `dma_enabled_o` rises one cycle after the edge that samples the allocation acknowledgement. The bench drives inputs on falling edges and pushes the expected outcome into a queue before each request. A falling-edge monitor pops and compares an entry exactly when `grant_valid_o` or `stall_o` is high, so every result is compared in the single cycle it is due. Flags are sampled on the falling edge that follows their pulse.

// File: rtl/xrt_pkg.sv
package xrt_pkg;
    typedef enum logic [1:0] {
        NEG_OFF  = 2'd0,
        NEG_WAIT = 2'd1,
        NEG_ON   = 2'd2
    } neg_state_e;

    typedef enum logic [1:0] {
        PICK_MBOX  = 2'd0,
        PICK_HEAD  = 2'd1,
        PICK_ZERO  = 2'd2,
        PICK_STALL = 2'd3
    } pick_e;
endpackage

// File: rtl/xrt_neg_fsm.sv
module xrt_neg_fsm
    import xrt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic notice_i,
    input  logic ack_i,
    output logic dma_on_o
);
    neg_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= NEG_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            NEG_OFF:  if (notice_i) state_d = NEG_WAIT;
            NEG_WAIT: if (ack_i)    state_d = NEG_ON;
            NEG_ON:   state_d = NEG_ON;
            default:  state_d = NEG_OFF;
        endcase
    end

    always_comb dma_on_o = (state_q == NEG_ON);
endmodule

// File: rtl/xrt_region_fifo.sv
module xrt_region_fifo #(
    parameter int DEPTH = 4,
    parameter int OFF_W = 12,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [OFF_W-1:0] push_off_i,
    input  logic [LEN_W-1:0] push_len_i,
    input  logic             pop_i,
    output logic [OFF_W-1:0] front_off_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [OFF_W-1:0] off_q [DEPTH];
    logic [LEN_W-1:0] len_q [DEPTH];
    logic [PW-1:0]    wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_i && (wr_q == PW'(i))) begin
                off_q[i] <= push_off_i;
                len_q[i] <= push_len_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= bump(wr_q);
            if (pop_i)  rd_q <= bump(rd_q);
            if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
            else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign front_off_o = off_q[rd_q];
    assign empty_o     = (cnt_q == '0);
    assign full_o      = (cnt_q == CNT_W'(DEPTH));

    logic unused_len;
    assign unused_len = ^len_q[rd_q];
endmodule

// File: rtl/xfer_region_tracker.sv
module xfer_region_tracker
    import xrt_pkg::*;
#(
    parameter int BUF_BYTES  = 2048,
    parameter int FRAG_BYTES = 128,
    parameter int FRAG_LIMIT = 3,
    parameter int MAX_OUT    = 4,
    parameter int LEN_W      = 12,
    localparam int OFF_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_notice_i,
    input  logic             alloc_ack_i,
    input  logic             req_valid_i,
    input  logic [LEN_W-1:0] req_len_i,
    input  logic             xfer_ack_i,
    output logic             grant_valid_o,
    output logic             grant_dma_o,
    output logic [OFF_W-1:0] grant_off_o,
    output logic [LEN_W-1:0] grant_len_o,
    output logic             stall_o,
    output logic             dma_enabled_o,
    output logic             ack_err_o
);
    localparam int MBOX_MAX = FRAG_BYTES * FRAG_LIMIT;
    localparam int CW       = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 2;

    logic             dma_on, fifo_empty, fifo_full, push, pop;
    logic [OFF_W-1:0] head_q, tail_off, push_off;
    logic [CW-1:0]    len_x, head_x, tail_x;
    pick_e            pick;

    xrt_neg_fsm u_neg (
        .clk      (clk),
        .rst_n    (rst_n),
        .notice_i (alloc_notice_i),
        .ack_i    (alloc_ack_i),
        .dma_on_o (dma_on)
    );

    xrt_region_fifo #(.DEPTH(MAX_OUT), .OFF_W(OFF_W), .LEN_W(LEN_W)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .push_off_i  (push_off),
        .push_len_i  (req_len_i),
        .pop_i       (pop),
        .front_off_o (tail_off),
        .empty_o     (fifo_empty),
        .full_o      (fifo_full)
    );

    assign len_x  = CW'(req_len_i);
    assign head_x = CW'(head_q);
    assign tail_x = CW'(tail_off);

    always_comb begin
        pick = PICK_STALL;
        if (!(dma_on && (len_x > CW'(MBOX_MAX))))       pick = PICK_MBOX;
        else if (fifo_full)                              pick = PICK_STALL;
        else if (fifo_empty)                             pick = (len_x <= CW'(BUF_BYTES)) ? PICK_ZERO : PICK_STALL;
        else if (head_x > tail_x) begin
            if (CW'(BUF_BYTES) - head_x >= len_x)        pick = PICK_HEAD;
            else if (tail_x >= len_x)                    pick = PICK_ZERO;
        end else if (tail_x - head_x >= len_x)           pick = PICK_HEAD;
    end

    assign push     = req_valid_i && ((pick == PICK_HEAD) || (pick == PICK_ZERO));
    assign push_off = (pick == PICK_HEAD) ? head_q : '0;
    assign pop      = xfer_ack_i && !fifo_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid_o <= 1'b0;
            grant_dma_o   <= 1'b0;
            grant_off_o   <= '0;
            grant_len_o   <= '0;
            stall_o       <= 1'b0;
            head_q        <= '0;
            ack_err_o     <= 1'b0;
        end else begin
            grant_valid_o <= 1'b0;
            stall_o       <= 1'b0;
            if (xfer_ack_i && fifo_empty) ack_err_o <= 1'b1;
            if (req_valid_i) begin
                unique case (pick)
                    PICK_MBOX: begin
                        grant_valid_o <= 1'b1;
                        grant_dma_o   <= 1'b0;
                        grant_off_o   <= '0;
                        grant_len_o   <= req_len_i;
                    end
                    PICK_HEAD: begin
                        grant_valid_o <= 1'b1;
                        grant_dma_o   <= 1'b1;
                        grant_off_o   <= head_q;
                        grant_len_o   <= req_len_i;
                        head_q        <= OFF_W'(head_x + len_x);
                    end
                    PICK_ZERO: begin
                        grant_valid_o <= 1'b1;
                        grant_dma_o   <= 1'b1;
                        grant_off_o   <= '0;
                        grant_len_o   <= req_len_i;
                        head_q        <= OFF_W'(len_x);
                    end
                    default: stall_o <= 1'b1;
                endcase
            end
        end
    end

    assign dma_enabled_o = dma_on;
endmodule

// File: rtl/xrt_checker.sv
module xrt_checker #(
    parameter int BUF_BYTES  = 2048,
    parameter int FRAG_BYTES = 128,
    parameter int FRAG_LIMIT = 3,
    parameter int LEN_W      = 12,
    parameter int OFF_W      = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid_i,
    input logic             grant_valid_o,
    input logic             grant_dma_o,
    input logic [OFF_W-1:0] grant_off_o,
    input logic [LEN_W-1:0] grant_len_o,
    input logic             stall_o,
    input logic             dma_enabled_o,
    input logic             ack_err_o
);
    localparam int CW = ((OFF_W > LEN_W) ? OFF_W : LEN_W) + 2;

    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_valid_o && stall_o));                                              // R1
    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> (grant_valid_o || stall_o));                               // R1
    AST_NO_SPONTANEOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> !(grant_valid_o || stall_o));                             // R1
    AST_DMA_AFTER_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && grant_dma_o) |-> dma_enabled_o);                         // R3
    AST_SHORT_MAILBOX: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && (CW'(grant_len_o) <= CW'(FRAG_BYTES * FRAG_LIMIT))) |-> !grant_dma_o); // R4
    AST_REGION_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && grant_dma_o) |-> (CW'(grant_off_o) + CW'(grant_len_o) <= CW'(BUF_BYTES))); // R13
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err_o |=> ack_err_o);                                                  // R12
    AST_NEG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        dma_enabled_o |=> dma_enabled_o);                                          // R3
endmodule

bind xfer_region_tracker xrt_checker #(
    .BUF_BYTES  (BUF_BYTES),
    .FRAG_BYTES (FRAG_BYTES),
    .FRAG_LIMIT (FRAG_LIMIT),
    .LEN_W      (LEN_W),
    .OFF_W      (OFF_W)
) u_xrt_checker (.*);

// File: tb/xfer_region_tracker_bench.sv
module xfer_region_tracker_bench;
    localparam int LEN_W = 12;
    localparam int OFF_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alloc_notice_i = 1'b0, alloc_ack_i = 1'b0, req_valid_i = 1'b0, xfer_ack_i = 1'b0;
    logic [LEN_W-1:0] req_len_i = '0;
    logic grant_valid_o, grant_dma_o, stall_o, dma_enabled_o, ack_err_o;
    logic [OFF_W-1:0] grant_off_o;
    logic [LEN_W-1:0] grant_len_o;

    always #10 clk = ~clk;

    xfer_region_tracker u_xfer_region_tracker (.*);

    typedef struct {
        bit    stall;
        bit    dma;
        int    off;
        int    len;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && (grant_valid_o || stall_o)) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R1 unexpected result", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(stall_o == e.stall, {e.tag, " stall"}, int'(stall_o), int'(e.stall));
                chk(grant_valid_o == !e.stall, {e.tag, " grant"}, int'(grant_valid_o), int'(!e.stall));
                if (!e.stall) begin
                    chk(grant_dma_o == e.dma, {e.tag, " path"}, int'(grant_dma_o), int'(e.dma));
                    chk(int'(grant_off_o) == e.off, {e.tag, " offset"}, int'(grant_off_o), e.off);
                    chk(int'(grant_len_o) == e.len, {e.tag, " length"}, int'(grant_len_o), e.len);
                end
            end
        end
    end

    task automatic send(input int len, input bit st, input bit dma, input int off, input string tag);
        exp_t e;
        e.stall = st; e.dma = dma; e.off = off; e.len = len; e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid_i = 1'b1;
        req_len_i   = LEN_W'(len);
        @(negedge clk);
        req_valid_i = 1'b0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); xfer_ack_i = 1'b1;
        @(negedge clk); xfer_ack_i = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R1 watchdog: actual hang expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2: reset state
        chk(!grant_valid_o && !stall_o, "R2 reset grant/stall", int'(grant_valid_o | stall_o), 0);
        chk(!dma_enabled_o && !ack_err_o, "R2 reset flags", int'(dma_enabled_o | ack_err_o), 0);
        rst_n = 1'b1;

        // R4: before negotiation every message uses the mailbox
        send(1000, 0, 0, 0, "R4 mailbox before negotiation");
        // R3: acknowledgement in NEG_OFF is ignored
        @(negedge clk); alloc_ack_i = 1'b1;
        @(negedge clk); alloc_ack_i = 1'b0;
        chk(!dma_enabled_o, "R3 ack without notice", int'(dma_enabled_o), 0);
        send(1000, 0, 0, 0, "R3 still mailbox");
        @(negedge clk); alloc_notice_i = 1'b1;
        @(negedge clk); alloc_notice_i = 1'b0;
        chk(!dma_enabled_o, "R3 waiting for ack", int'(dma_enabled_o), 0);
        @(negedge clk); alloc_ack_i = 1'b1;
        @(negedge clk); alloc_ack_i = 1'b0;
        chk(dma_enabled_o, "R3 enabled after ack", int'(dma_enabled_o), 1);

        send(384, 0, 0, 0, "R4 384 bytes boundary");
        send(385, 0, 1, 0, "R7 first region at zero");
        send(100, 0, 0, 0, "R5 short after buffer");
        send(1000, 0, 1, 385, "R6 head placement");
        send(600, 0, 1, 1385, "R6 second head placement");
        send(500, 1, 0, 0, "R8 no room stall");
        pulse_ack();
        send(500, 1, 0, 0, "R10 one release not enough");
        pulse_ack();
        send(500, 0, 1, 0, "R8 wrap to zero");
        send(900, 1, 0, 0, "R9 gap too small");
        send(885, 0, 1, 500, "R9 exact fit");
        send(400, 1, 0, 0, "R9 zero gap");
        pulse_ack();
        pulse_ack();
        pulse_ack();
        chk(!ack_err_o, "R12 no error yet", int'(ack_err_o), 0);
        pulse_ack();
        chk(ack_err_o, "R12 spurious ack flagged", int'(ack_err_o), 1);
        send(2049, 1, 0, 0, "R13 oversize stalls");
        send(400, 0, 1, 0, "R12 state unchanged, restart at zero");
        send(400, 0, 1, 400, "R11 fill 2");
        send(400, 0, 1, 800, "R11 fill 3");
        send(400, 0, 1, 1200, "R11 fill 4");
        send(400, 1, 0, 0, "R11 outstanding limit");
        pulse_ack();
        send(400, 0, 1, 1600, "R10 release allows next");
        chk(ack_err_o, "R12 flag stays set", int'(ack_err_o), 1);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R1 all results arrived", exp_q.size(), 0);
        done = 1'b1;
        summary();
    end
endmodule